// File: doc/BRIEF.md
# Halfword byte-swapping DMA adapter

This block sits between the DMA request port of a network controller that keeps its buffers in little-endian order and a memory port that stores halfwords in big-endian order. The controller presents one request at a time: a byte offset, a byte count, a read/write direction and a flag that selects native order or byte-swapped order. The adapter forms the memory address by bitwise OR of the offset with a programmable base value, then moves the transfer to memory one 16-bit halfword per beat with a valid/ready handshake.

In swapped mode the adapter clears bit 0 of both the address and the byte count, so every beat is a full, aligned halfword. It exchanges the two bytes of each halfword on the way to memory for writes and on the way back for reads. Swapped writes are also cut into bursts of bounded size, with the address carried on across bursts. In native mode the data, address and count are left as given, and an odd count ends with a single-byte beat. A one-cycle completion pulse follows the final beat.

Top module: `hwdma_swap_adapter`

## Requirements
- R1: The address of the first beat equals `req_offset` bitwise ORed with the base value last loaded through `base_load`/`base_value`, not their sum (base 0x1010 with offset 0x18 gives 0x1018). The base is zero after reset.
- R2: With `req_native` low, bit 0 of the formed address and bit 0 of `req_len` are cleared before the transfer starts, and every beat has `mem_be` = 2'b11.
- R3: On a swapped read, `rd_data[15:8]` equals `mem_rdata[7:0]` and `rd_data[7:0]` equals `mem_rdata[15:8]` for each beat; `rd_valid` is high exactly in cycles where a read beat completes (`mem_valid` and `mem_ready`).
- R4: On a swapped write, `mem_wdata[15:8]` equals `wr_data[7:0]` and `mem_wdata[7:0]` equals `wr_data[15:8]` for each beat.
- R5: With `req_native` high, data passes unchanged in both directions, the address and length are not realigned, and an odd length ends with a beat whose `mem_be` is 2'b01 (bit 0 marks the byte at `mem_addr`, bit 1 the byte at `mem_addr`+1).
- R6: A swapped write is split into bursts of at most CHUNK_BYTES (default 64) bytes; `mem_sob` is high on the first beat of each burst, and the address continues without a gap across bursts.
- R7: Reads, and writes in native mode, run as a single burst whatever their length, with `mem_sob` high only on the first beat.
- R8: Each completed beat advances `mem_addr` by 2; `done` is high for exactly one cycle, the cycle after the final beat completes, and no beat is offered while `done` is high.
- R9: A request whose effective length is zero (zero, or one in swapped mode) raises `done` in the cycle after acceptance and issues no beat.
- R10: `req_ready` is high only when the adapter is idle; a request presented while a transfer is running is ignored and leaves that transfer unchanged.
- R11: A write beat is offered only while `wr_valid` is high, `wr_ready` follows `mem_ready` during a write beat, and a stalled beat keeps its address and byte enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_load | input | 1 | Loads `base_value` into the base register |
| base_value | input | AW | New base value |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Adapter idle, request taken this cycle if valid |
| req_offset | input | AW | Byte offset of the transfer |
| req_len | input | LW | Byte count of the transfer |
| req_write | input | 1 | 1 = controller to memory, 0 = memory to controller |
| req_native | input | 1 | 1 = native order, 0 = swap halfwords and realign |
| wr_valid | input | 1 | Write halfword available from the controller |
| wr_ready | output | 1 | Write halfword consumed |
| wr_data | input | 16 | Write halfword from the controller |
| rd_valid | output | 1 | Read halfword delivered this cycle |
| rd_data | output | 16 | Read halfword to the controller |
| mem_valid | output | 1 | Memory beat offered |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_write | output | 1 | Beat direction, 1 = write |
| mem_addr | output | AW | Byte address of the beat |
| mem_be | output | 2 | Byte enables of the beat |
| mem_sob | output | 1 | First beat of a burst |
| mem_wdata | output | 16 | Write halfword to memory |
| mem_rdata | input | 16 | Read halfword from memory, valid with the handshake |
| done | output | 1 | One-cycle completion pulse |

## Verification
The two functions that can meet in one cycle are the final beat of one burst of a swapped write and the start of the next burst, and likewise the final beat of a transfer and the completion pulse; a burst boundary can also coincide with a stall from memory or a pause in write data. The bench provokes these with writes of 70 and 130 bytes, which end in short tail bursts, under a pseudo-random `mem_ready` and `wr_valid`. Each beat is judged against a queue of expected address, byte enable, burst marker and data built from the requirements, and the cycle of `done` is compared with the cycle of the last completed beat.

// File: rtl/hwsa_pkg.sv
package hwsa_pkg;

   // Sequencer states; the order has no meaning outside the sequencer.
   typedef enum logic [1:0] {
      SEQ_IDLE   = 2'd0,
      SEQ_SETUP  = 2'd1,
      SEQ_MOVE   = 2'd2,
      SEQ_FINISH = 2'd3
   } seq_state_e;

   // Bytes moved by one memory beat.
   localparam int HALF_BYTES = 2;

endpackage

// File: rtl/hwsa_base_reg.sv
module hwsa_base_reg #(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] value,
   output logic [AW-1:0] base
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base <= '0;
      end else if (load) begin
         base <= value;
      end
   end

endmodule

// File: rtl/hwsa_req_form.sv
module hwsa_req_form #(
   parameter int AW = 32,
   parameter int LW = 16
) (
   input  logic [AW-1:0] offset,
   input  logic [AW-1:0] base,
   input  logic [LW-1:0] len,
   input  logic          swap,
   output logic [AW-1:0] addr,
   output logic [LW-1:0] len_eff
);

   localparam logic [AW-1:0] ADDR_LSB = AW'(1);
   localparam logic [LW-1:0] LEN_LSB  = LW'(1);

   // Base is merged by OR; swapped transfers are forced to whole halfwords.
   always_comb begin
      addr    = offset | base;
      len_eff = len;
      if (swap) begin
         addr    = addr & ~ADDR_LSB;
         len_eff = len_eff & ~LEN_LSB;
      end
   end

endmodule

// File: rtl/hwsa_lane_swap.sv
module hwsa_lane_swap #(
   parameter int LANES = 2
) (
   input  logic [8*LANES-1:0] din,
   input  logic               swap,
   output logic [8*LANES-1:0] dout
);

   logic [8*LANES-1:0] reversed;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign reversed[8*g +: 8] = din[8*(LANES-1-g) +: 8];
   end

   assign dout = swap ? reversed : din;

endmodule

// File: rtl/hwsa_seq.sv
module hwsa_seq
   import hwsa_pkg::*;
#(
   parameter int AW          = 32,
   parameter int LW          = 16,
   parameter int CHUNK_BYTES = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] start_addr,
   input  logic [LW-1:0] start_len,
   input  logic          start_write,
   input  logic          start_swap,
   input  logic          src_valid,
   input  logic          sink_ready,
   output logic          idle,
   output logic          beat_valid,
   output logic [AW-1:0] beat_addr,
   output logic [1:0]    beat_be,
   output logic          beat_sob,
   output logic          beat_write,
   output logic          beat_swap,
   output logic          src_ready,
   output logic          fin
);

   localparam logic [LW-1:0] CHUNK_LEN = LW'(CHUNK_BYTES);
   localparam logic [LW-1:0] ONE       = LW'(1);
   localparam logic [LW-1:0] TWO       = LW'(HALF_BYTES);

   seq_state_e    state;
   logic [AW-1:0] addr_q;
   logic [LW-1:0] rem_q;
   logic [LW-1:0] beats_q;
   logic          write_q;
   logic          swap_q;
   logic          sob_q;

   logic [LW-1:0] chunk_len;
   logic [LW:0]   beats_ext;
   logic [LW-1:0] chunk_beats;
   logic [LW-1:0] rem_next;
   logic          hs;

   // Burst sizing: only swapped writes are bounded.
   always_comb begin
      if (write_q && swap_q && (rem_q > CHUNK_LEN)) begin
         chunk_len = CHUNK_LEN;
      end else begin
         chunk_len = rem_q;
      end
      beats_ext   = ({1'b0, chunk_len} + {{LW{1'b0}}, 1'b1}) >> 1;
      chunk_beats = beats_ext[LW-1:0];
      rem_next    = (rem_q == ONE) ? '0 : (rem_q - TWO);
   end

   assign idle       = (state == SEQ_IDLE);
   assign fin        = (state == SEQ_FINISH);
   assign beat_valid = (state == SEQ_MOVE) && (!write_q || src_valid);
   assign src_ready  = (state == SEQ_MOVE) && write_q && sink_ready;
   assign hs         = beat_valid && sink_ready;
   assign beat_addr  = addr_q;
   assign beat_be    = (rem_q == ONE) ? 2'b01 : 2'b11;
   assign beat_sob   = sob_q;
   assign beat_write = write_q;
   assign beat_swap  = swap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= SEQ_IDLE;
         addr_q  <= '0;
         rem_q   <= '0;
         beats_q <= '0;
         write_q <= 1'b0;
         swap_q  <= 1'b0;
         sob_q   <= 1'b0;
      end else begin
         unique case (state)
            SEQ_IDLE: begin
               if (start) begin
                  addr_q  <= start_addr;
                  rem_q   <= start_len;
                  write_q <= start_write;
                  swap_q  <= start_swap;
                  state   <= (start_len == '0) ? SEQ_FINISH : SEQ_SETUP;
               end
            end
            SEQ_SETUP: begin
               beats_q <= chunk_beats;
               sob_q   <= 1'b1;
               state   <= SEQ_MOVE;
            end
            SEQ_MOVE: begin
               if (hs) begin
                  addr_q  <= addr_q + AW'(HALF_BYTES);
                  rem_q   <= rem_next;
                  beats_q <= beats_q - ONE;
                  sob_q   <= 1'b0;
                  if (beats_q == ONE) begin
                     state <= (rem_next == '0) ? SEQ_FINISH : SEQ_SETUP;
                  end
               end
            end
            SEQ_FINISH: begin
               state <= SEQ_IDLE;
            end
            default: begin
               state <= SEQ_IDLE;
            end
         endcase
      end
   end

endmodule

// File: rtl/hwdma_swap_adapter.sv
module hwdma_swap_adapter #(
   parameter int AW          = 32,
   parameter int LW          = 16,
   parameter int CHUNK_BYTES = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          base_load,
   input  logic [AW-1:0] base_value,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [AW-1:0] req_offset,
   input  logic [LW-1:0] req_len,
   input  logic          req_write,
   input  logic          req_native,
   input  logic          wr_valid,
   output logic          wr_ready,
   input  logic [15:0]   wr_data,
   output logic          rd_valid,
   output logic [15:0]   rd_data,
   output logic          mem_valid,
   input  logic          mem_ready,
   output logic          mem_write,
   output logic [AW-1:0] mem_addr,
   output logic [1:0]    mem_be,
   output logic          mem_sob,
   output logic [15:0]   mem_wdata,
   input  logic [15:0]   mem_rdata,
   output logic          done
);

   localparam int LANES = hwsa_pkg::HALF_BYTES;

   // Elaboration-time parameter checks.
   if (CHUNK_BYTES < LANES || (CHUNK_BYTES % LANES) != 0) begin : g_bad_chunk
      $error("CHUNK_BYTES must be a positive multiple of the beat size");
   end
   if (LW < 2 || LW > 30 || CHUNK_BYTES >= (1 << LW)) begin : g_bad_len
      $error("LW must hold CHUNK_BYTES and stay below 31 bits");
   end
   if (AW < 2) begin : g_bad_addr
      $error("AW must be at least 2");
   end

   logic [AW-1:0] base_q;
   logic [AW-1:0] form_addr;
   logic [LW-1:0] form_len;
   logic          idle;
   logic          swap_act;
   logic          start;

   assign start     = req_valid && idle;
   assign req_ready = idle;

   hwsa_base_reg #(
      .AW (AW)
   ) u_base (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (base_load),
      .value (base_value),
      .base  (base_q)
   );

   hwsa_req_form #(
      .AW (AW),
      .LW (LW)
   ) u_form (
      .offset  (req_offset),
      .base    (base_q),
      .len     (req_len),
      .swap    (!req_native),
      .addr    (form_addr),
      .len_eff (form_len)
   );

   hwsa_seq #(
      .AW          (AW),
      .LW          (LW),
      .CHUNK_BYTES (CHUNK_BYTES)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .start_addr  (form_addr),
      .start_len   (form_len),
      .start_write (req_write),
      .start_swap  (!req_native),
      .src_valid   (wr_valid),
      .sink_ready  (mem_ready),
      .idle        (idle),
      .beat_valid  (mem_valid),
      .beat_addr   (mem_addr),
      .beat_be     (mem_be),
      .beat_sob    (mem_sob),
      .beat_write  (mem_write),
      .beat_swap   (swap_act),
      .src_ready   (wr_ready),
      .fin         (done)
   );

   hwsa_lane_swap #(
      .LANES (LANES)
   ) u_wr_swap (
      .din  (wr_data),
      .swap (swap_act),
      .dout (mem_wdata)
   );

   hwsa_lane_swap #(
      .LANES (LANES)
   ) u_rd_swap (
      .din  (mem_rdata),
      .swap (swap_act),
      .dout (rd_data)
   );

   assign rd_valid = mem_valid && mem_ready && !mem_write;

endmodule

// File: rtl/hwdma_swap_adapter_chk.sv
module hwdma_swap_adapter_chk #(
   parameter int AW          = 32,
   parameter int LW          = 16,
   parameter int CHUNK_BYTES = 64
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_ready,
   input logic          wr_valid,
   input logic          wr_ready,
   input logic          mem_valid,
   input logic          mem_ready,
   input logic          mem_write,
   input logic [AW-1:0] mem_addr,
   input logic [1:0]    mem_be,
   input logic          mem_sob,
   input logic          swap_act,
   input logic          done
);

   localparam logic [LW-1:0] BURST_BEATS = LW'(CHUNK_BYTES / 2);

   logic          beat_hs;
   logic [LW-1:0] run_cnt;

   assign beat_hs = mem_valid && mem_ready;

   // Beats completed so far in the current burst.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt <= '0;
      end else if (beat_hs) begin
         run_cnt <= mem_sob ? LW'(1) : (run_cnt + LW'(1));
      end
   end

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!mem_valid && !wr_ready && !done)); // R10

   AST_SWAP_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && swap_act) |-> (!mem_addr[0] && mem_be == 2'b11)); // R2

   AST_BE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> (mem_be != 2'b00)); // R5

   AST_BURST_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_hs && mem_write && swap_act && !mem_sob) |-> (run_cnt < BURST_BEATS)); // R6

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      beat_hs |=> (mem_addr == $past(mem_addr) + AW'(2))); // R8

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8

   AST_DONE_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_valid); // R8

   AST_WR_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_write) |-> (wr_valid && (wr_ready == mem_ready))); // R11

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> ($stable(mem_addr) && $stable(mem_be))); // R11

endmodule

bind hwdma_swap_adapter hwdma_swap_adapter_chk #(
   .AW          (AW),
   .LW          (LW),
   .CHUNK_BYTES (CHUNK_BYTES)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .wr_valid  (wr_valid),
   .wr_ready  (wr_ready),
   .mem_valid (mem_valid),
   .mem_ready (mem_ready),
   .mem_write (mem_write),
   .mem_addr  (mem_addr),
   .mem_be    (mem_be),
   .mem_sob   (mem_sob),
   .swap_act  (swap_act),
   .done      (done)
);

// File: tb/test_hwdma_swap_adapter.sv
module test_hwdma_swap_adapter;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        base_load = 1'b0;
   logic [31:0] base_value = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_offset = '0;
   logic [15:0] req_len = '0;
   logic        req_write = 1'b0;
   logic        req_native = 1'b0;
   logic        wr_valid;
   logic        wr_ready;
   logic [15:0] wr_data;
   logic        rd_valid;
   logic [15:0] rd_data;
   logic        mem_valid;
   logic        mem_ready;
   logic        mem_write;
   logic [31:0] mem_addr;
   logic [1:0]  mem_be;
   logic        mem_sob;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata;
   logic        done;

   always #2 clk = ~clk;

   hwdma_swap_adapter i_hwdma_swap_adapter (
      .clk (clk), .rst_n (rst_n),
      .base_load (base_load), .base_value (base_value),
      .req_valid (req_valid), .req_ready (req_ready),
      .req_offset (req_offset), .req_len (req_len),
      .req_write (req_write), .req_native (req_native),
      .wr_valid (wr_valid), .wr_ready (wr_ready), .wr_data (wr_data),
      .rd_valid (rd_valid), .rd_data (rd_data),
      .mem_valid (mem_valid), .mem_ready (mem_ready), .mem_write (mem_write),
      .mem_addr (mem_addr), .mem_be (mem_be), .mem_sob (mem_sob),
      .mem_wdata (mem_wdata), .mem_rdata (mem_rdata), .done (done)
   );

   typedef struct {
      logic [31:0] addr;
      logic [1:0]  be;
      logic        sob;
      logic        wr;
      logic [15:0] data;
      string       atag;
      string       stag;
      string       dtag;
   } beat_t;

   beat_t       exp_q[$];
   int          n_chk = 0;
   int          n_bad = 0;
   int          cyc = 0;
   int          last_hs_cyc = -1;
   int          wsent = 0;
   logic [31:0] base_m = '0;
   logic [7:0]  lfsr = 8'h5B;
   logic [15:0] wcnt = '0;
   bit          finished = 1'b0;

   function automatic logic [15:0] sw(input logic [15:0] x);
      return {x[7:0], x[15:8]};
   endfunction

   function automatic logic [15:0] memf(input logic [31:0] a);
      return {a[8:1] ^ 8'hA5, a[7:0] + 8'h3C};
   endfunction

   function automatic logic [15:0] wordf(input logic [15:0] n);
      return {n[7:0] ^ 8'hC3, n[7:0] + 8'h11};
   endfunction

   // Memory and write-source models with pseudo-random pacing.
   assign mem_rdata = memf(mem_addr);
   assign mem_ready = lfsr[1] | lfsr[4];
   assign wr_valid  = lfsr[6] | lfsr[2];
   assign wr_data   = wordf(wcnt);

   always @(posedge clk) begin
      cyc  <= cyc + 1;
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (wr_valid && wr_ready) wcnt <= wcnt + 16'd1;
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   // Monitor: pops one expected beat per completed memory handshake.
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (mem_valid && mem_write) begin
            chk(wr_valid === 1'b1, "R11", "write beat without source data", 32'(wr_valid), 32'd1);
         end
         if (mem_valid && mem_ready) begin
            last_hs_cyc = cyc + 1;
            if (exp_q.size() == 0) begin
               chk(1'b0, "R10", "unexpected beat address", mem_addr, 32'hFFFF_FFFF);
            end else begin
               beat_t e;
               e = exp_q.pop_front();
               chk(mem_addr === e.addr, e.atag, "beat address", mem_addr, e.addr);
               chk(mem_be === e.be, "R5", "byte enables", 32'(mem_be), 32'(e.be));
               chk(mem_sob === e.sob, e.stag, "burst start marker", 32'(mem_sob), 32'(e.sob));
               chk(mem_write === e.wr, "R8", "beat direction", 32'(mem_write), 32'(e.wr));
               if (e.wr) begin
                  chk(mem_wdata === e.data, e.dtag, "write data", 32'(mem_wdata), 32'(e.data));
               end else begin
                  chk(rd_valid === 1'b1, "R3", "read strobe", 32'(rd_valid), 32'd1);
                  chk(rd_data === e.data, e.dtag, "read data", 32'(rd_data), 32'(e.data));
               end
            end
         end else begin
            if (rd_valid) chk(1'b0, "R3", "read strobe without beat", 32'd1, 32'd0);
         end
      end
   end

   task automatic set_base(input logic [31:0] v);
      @(negedge clk);
      base_load  = 1'b1;
      base_value = v;
      @(negedge clk);
      base_load  = 1'b0;
      base_m     = v;
   endtask

   // Driver: builds the expected beats from the requirements, then issues the request.
   task automatic run_req(input logic [31:0] off, input logic [15:0] len,
                          input bit wr, input bit nat, input bit poke);
      logic [31:0] a;
      int          rem;
      int          acc;
      int          t;
      bit          empty;
      a   = off | base_m;
      rem = int'(len);
      if (!nat) begin
         a[0] = 1'b0;
         rem  = rem & ~1;
      end
      empty = (rem == 0);
      while (rem > 0) begin
         int chunk;
         chunk = (wr && !nat && rem > 64) ? 64 : rem;
         for (int i = 0; i < chunk; i += 2) begin
            beat_t e;
            e.addr = a;
            e.be   = (chunk - i >= 2) ? 2'b11 : 2'b01;
            e.sob  = (i == 0);
            e.wr   = wr;
            e.atag = nat ? "R1" : "R2";
            e.stag = (wr && !nat) ? "R6" : "R7";
            if (wr) begin
               e.data = nat ? wordf(16'(wsent)) : sw(wordf(16'(wsent)));
               e.dtag = nat ? "R5" : "R4";
               wsent++;
            end else begin
               e.data = nat ? memf(a) : sw(memf(a));
               e.dtag = nat ? "R5" : "R3";
            end
            exp_q.push_back(e);
            a = a + 32'd2;
         end
         rem = rem - chunk;
      end
      @(negedge clk);
      req_offset = off;
      req_len    = len;
      req_write  = wr;
      req_native = nat;
      req_valid  = 1'b1;
      while (!req_ready) @(negedge clk);
      acc = cyc + 1;
      @(negedge clk);
      req_valid = 1'b0;
      if (poke) begin
         // R10: a second request during a running transfer must be ignored.
         req_offset = 32'hDEAD_0000;
         req_len    = 16'd2;
         req_write  = !wr;
         req_valid  = 1'b1;
         for (int k = 0; k < 3; k++) begin
            chk(req_ready === 1'b0, "R10", "ready while busy", 32'(req_ready), 32'd0);
            @(negedge clk);
         end
         req_valid = 1'b0;
      end
      t = 0;
      while (!done && t < 4000) begin
         @(negedge clk);
         t++;
      end
      chk(done === 1'b1, "R8", "completion pulse seen", 32'(done), 32'd1);
      if (empty) begin
         chk(cyc == acc, "R9", "empty request completion cycle", 32'(cyc), 32'(acc));
      end else begin
         chk(cyc == last_hs_cyc, "R8", "completion cycle after last beat", 32'(cyc), 32'(last_hs_cyc));
      end
      chk(exp_q.size() == 0, empty ? "R9" : "R8", "beats left at completion",
          32'(exp_q.size()), 32'd0);
      exp_q.delete();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready === 1'b1, "R10", "idle after reset", 32'(req_ready), 32'd1);
      chk(mem_valid === 1'b0, "R8", "no beat after reset", 32'(mem_valid), 32'd0);
      chk(done === 1'b0, "R8", "no completion after reset", 32'(done), 32'd0);

      // R1: base is zero after reset, so the offset passes through.
      run_req(32'h0000_0204, 16'd4, 1'b0, 1'b1, 1'b0);

      set_base(32'h0000_1010);
      // R6: 70-byte swapped write at odd offset, bursts of 32 and 3 beats.
      run_req(32'h0000_0101, 16'd70, 1'b1, 1'b0, 1'b1);
      // R3: 131-byte swapped read, trimmed to 130, one burst of 65 beats.
      run_req(32'h0000_2003, 16'd131, 1'b0, 1'b0, 1'b1);
      // R5: native write, odd address and length kept, last beat single byte.
      run_req(32'h0000_0003, 16'd5, 1'b1, 1'b1, 1'b0);
      // R1: OR differs from a sum here (0x1018, not 0x1028).
      run_req(32'h0000_0018, 16'd3, 1'b0, 1'b1, 1'b0);
      // R7: long native write stays one burst.
      run_req(32'h0000_0040, 16'd100, 1'b1, 1'b1, 1'b1);
      // R9: length one in swapped mode, and length zero in native mode.
      run_req(32'h0000_0301, 16'd1, 1'b1, 1'b0, 1'b0);
      run_req(32'h0000_0300, 16'd0, 1'b0, 1'b1, 1'b0);

      set_base(32'hF000_0000);
      // R6: 130 bytes split 64, 64, 2.
      run_req(32'h0000_0F01, 16'd130, 1'b1, 1'b0, 1'b1);
      // R6: exactly one full burst.
      run_req(32'h0000_0080, 16'd64, 1'b1, 1'b0, 1'b0);
      // R4: short swapped write.
      run_req(32'h0000_0007, 16'd6, 1'b1, 1'b0, 1'b0);

      finished = 1'b1;
      summary();
      $finish;
   end

   // Watchdog: a hung run counts as one failed check.
   always @(posedge clk) begin
      if (cyc > 100000 && !finished) begin
         finished = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not complete, actual %0d cycles expected fewer", cyc);
         summary();
         $finish;
      end
   end

endmodule